// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synthesizable model of a byte-addressed serial EEPROM that answers as a slave on an I2C bus. Its word address is 17 bits wide, enough for 2^17 bytes seen as 512 pages of 256 bytes. For simulation the stored array is cut down by the parameter `MEM_AW`. The stored index keeps word-address bit 16 and the low `MEM_AW-1` bits, so the page bit can still be observed. Both bus lines pass through a synchronizer. They are sampled on the system clock, which must run much faster than SCL. The block pulls SDA low through an open-drain output-enable.

A transfer opens with a device byte. That byte holds a fixed 5-bit prefix, one strap bit taken from a pin, the word-address bit 16 and the direction bit. A write can be followed by the high and low word-address bytes and then by any number of data bytes. Data bytes land in a one-page staging buffer and reach the array only when STOP is seen. Reads stream bytes from an internal address counter for as long as the master acknowledges. A random read is a write of only the two address bytes, then a repeated START and a read.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The slave acknowledges a device byte (bit 7 sent first) only when bits 7:3 equal 10100 and bit 2 equals `strap_i`. Bit 0 is the direction (0 write, 1 read). On a mismatch it gives no ACK and leaves SDA released until the next START.
- R2: In a write-direction device byte, bit 1 becomes word-address bit 16. The next byte supplies bits 15:8 and the byte after that supplies bits 7:0. Addresses that differ only in bit 16 hold separate bytes.
- R3: A byte write is device byte (write), high address, low address, one data byte, STOP. Each of these four bytes is acknowledged and the data byte is stored at that address.
- R4: In a multi-byte write, only address bits 7:0 advance after each data byte. After byte 0xFF of a page the address wraps to byte 0x00 of the same page.
- R5: Written bytes reach the array only on STOP. A repeated START before STOP discards every staged byte of that write.
- R6: A read that supplies no address returns the byte at the internal counter and then advances the counter by one. After a random read the counter points one past the byte that was read.
- R7: A random read (address write, repeated START, device byte with read direction, master NACK, STOP) returns the stored byte at the supplied address.
- R8: A read continues through incrementing addresses while the master ACKs. It crosses page boundaries, and the counter wraps from 0x1FFFF to 0x00000.
- R9: Read data goes out MSB first. SDA is released during the master's acknowledge clock, and after a NACK the slave drives nothing more.
- R10: A START or STOP in the middle of a byte abandons that byte. After a START the slave expects a new device byte, and a partial data byte is never stored.
- R11: Reset releases SDA and clears the address counter to zero. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Strap level compared against bit 2 of the device byte |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND of all drivers) |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The hardest case to reach is the commit rule. A repeated START must drop the staged bytes, while a STOP must commit them. Nothing visible changes at the pins when either happens. The bench reaches it by sending a data byte to a location with known contents, then issuing a repeated START that leads straight into a random read of the same location. It also sends a STOP three bits into a data byte. In both cases the old value must come back. Address wrap inside a page and counter wrap at the top of the array are reached by starting a write at offset 0xFE and a read at 0x1FFFF.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int WA_W = 17;  // full word-address width
  localparam int PG_W = 8;   // in-page offset width (256-byte page)

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DAT
  } kind_t;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw;
  logic [NLINE-1:0] synced;
  logic [NLINE-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl_s     = synced[1];
  assign sda_s     = synced[0];
  assign scl_rise  = synced[1] & ~prev[1];
  assign scl_fall  = ~synced[1] & prev[1];
  // SDA edges only count while SCL is high on both this and the last sample
  assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
  import eep_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [PG_W-1:0]      wr_idx,
  input  logic [7:0]           wr_data,
  input  logic                 discard,
  input  logic                 commit_req,
  input  logic [MEM_AW-PG_W-1:0] commit_pg,
  output logic                 busy,
  output logic                 mem_we,
  output logic [MEM_AW-1:0]    mem_waddr,
  output logic [7:0]           mem_wdata
);
  localparam int PAGE  = 1 << PG_W;
  localparam int PGS_W = MEM_AW - PG_W;

  logic [7:0]      buf_q [PAGE];
  logic [PAGE-1:0] vld;
  logic [PG_W-1:0] idx;
  logic [PGS_W-1:0] pg_q;

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      busy      <= 1'b0;
      idx       <= '0;
      pg_q      <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        mem_we    <= vld[idx];
        mem_waddr <= {pg_q, idx};
        mem_wdata <= buf_q[idx];
        idx       <= idx + 1'b1;
        if (idx == {PG_W{1'b1}}) begin
          busy <= 1'b0;
          vld  <= '0;
        end
      end else if (discard) begin
        vld <= '0;
      end else if (commit_req && |vld) begin
        busy <= 1'b1;
        idx  <= '0;
        pg_q <= commit_pg;
      end else if (wr_en) begin
        vld[wr_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            strap,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            busy,
  input  logic [7:0]      rdata,
  output logic            sda_oe,
  output st_t             st,
  output logic [WA_W-1:0] ptr,
  output logic            wr_en,
  output logic [PG_W-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            discard,
  output logic            commit_req
);
  localparam logic [WA_W-1:0] ONE      = 1;
  localparam logic [4:0]      DEV_PFX  = 5'b10100;

  kind_t      kind;
  logic [3:0] bitc;
  logic [7:0] sh;
  logic       rd;
  logic       m_ack;
  logic       p0_h;
  logic [7:0] ahi_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind       <= K_DEV;
      sda_oe     <= 1'b0;
      ptr        <= '0;
      bitc       <= '0;
      sh         <= '0;
      rd         <= 1'b0;
      m_ack      <= 1'b0;
      p0_h       <= 1'b0;
      ahi_h      <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      discard    <= 1'b0;
      commit_req <= 1'b0;
    end else begin
      wr_en      <= 1'b0;
      discard    <= 1'b0;
      commit_req <= 1'b0;
      if (busy) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        sda_oe     <= 1'b0;
        commit_req <= 1'b1;
      end else if (start_det) begin
        st      <= S_RX;
        kind    <= K_DEV;
        bitc    <= '0;
        rd      <= 1'b0;
        sda_oe  <= 1'b0;
        discard <= 1'b1;
      end else begin
        unique case (st)
          S_IDLE: ;
          S_RX: begin
            if (scl_rise && bitc != 4'd8) begin
              sh   <= {sh[6:0], sda_s};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              bitc   <= '0;
              st     <= S_RX_ACK;
              sda_oe <= 1'b1;
              unique case (kind)
                K_DEV: begin
                  if (sh[7:2] == {DEV_PFX, strap}) begin
                    rd <= sh[0];
                    if (!sh[0]) begin
                      p0_h <= sh[1];
                      kind <= K_AHI;
                    end
                  end else begin
                    st     <= S_IDLE;
                    sda_oe <= 1'b0;
                  end
                end
                K_AHI: begin
                  ahi_h <= sh;
                  kind  <= K_ALO;
                end
                K_ALO: begin
                  ptr  <= {p0_h, ahi_h, sh};
                  kind <= K_DAT;
                end
                K_DAT: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr[PG_W-1:0];
                  wr_data <= sh;
                  ptr     <= {ptr[WA_W-1:PG_W], ptr[PG_W-1:0] + 1'b1};
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                sh     <= rdata;
                sda_oe <= ~rdata[7];
                bitc   <= 4'd1;
                ptr    <= ptr + ONE;
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                bitc   <= '0;
                st     <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitc == 4'd8) begin
                sda_oe <= 1'b0;
                bitc   <= '0;
                st     <= S_TX_ACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                bitc   <= bitc + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                sh     <= rdata;
                sda_oe <= ~rdata[7];
                bitc   <= 4'd1;
                ptr    <= ptr + ONE;
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int MEM_AW      = 10,  // stored bytes = 2**MEM_AW, at least PG_W+2
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PGS_W = MEM_AW - PG_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_t  st;
  logic [WA_W-1:0] ptr;
  logic sda_oe;
  logic wr_en, discard, commit_req, busy;
  logic [PG_W-1:0] wr_idx;
  logic [7:0] wr_data;
  logic mem_we;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [PGS_W-1:0] commit_pg;

  eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_proto u_proto (
    .clk(clk), .rst(rst), .strap(strap_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .busy(busy),
    .rdata(mem_rdata), .sda_oe(sda_oe), .st(st), .ptr(ptr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .discard(discard), .commit_req(commit_req)
  );

  // reduced array keeps address bit 16 plus the low MEM_AW-1 bits
  assign mem_raddr = {ptr[WA_W-1], ptr[MEM_AW-2:0]};
  assign commit_pg = {ptr[WA_W-1], ptr[MEM_AW-2:PG_W]};

  eep_page_buf #(.MEM_AW(MEM_AW)) u_pbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .discard(discard), .commit_req(commit_req), .commit_pg(commit_pg),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eep_array #(.AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign sda_oe_o = sda_oe;
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            scl_s,
  input logic            stop_det,
  input logic            sda_oe,
  input st_t             st,
  input logic            busy,
  input logic            wr_en,
  input logic [WA_W-1:0] ptr
);
  // R9: no driving of SDA continues past a STOP
  assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R9: the slave only starts pulling SDA while the clock is low
  assert_drive_begins_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R1: an idle slave (including after an address mismatch) leaves SDA alone
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe);

  // R4: staging a data byte never changes the page part of the address
  assert_page_held_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ptr[WA_W-1:PG_W] == $past(ptr[WA_W-1:PG_W]));

  // R5: while the array is being updated the bus side stays idle
  assert_commit_idle_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (st == S_IDLE && !wr_en));
endmodule

bind i2c_eeprom_slave eep_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det), .sda_oe(sda_oe),
  .st(st), .busy(busy), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap = 1'b1;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = ~(m_low | sda_oe);

  always #5 clk = ~clk;

  i2c_eeprom_slave #(.MEM_AW(10), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .strap_i(strap), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_run = 0;
  int n_fail = 0;

  // {address[16:0], data[7:0]}
  localparam logic [24:0] VEC [6] = '{
    {17'h00123, 8'h3C}, {17'h10123, 8'hC3}, {17'h0AB40, 8'h5A},
    {17'h1F00F, 8'h81}, {17'h00055, 8'h00}, {17'h12377, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] devw(input logic p0);
    return {5'b10100, strap, p0, 1'b0};
  endfunction

  function automatic logic [7:0] devr();
    return {5'b10100, strap, 1'b0, 1'b1};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP);
    m_low = 1'b1; tick(HP);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(HP);
    scl_m = 1'b1; tick(HP);
    m_low = 1'b0; tick(HP);
    tick(320);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      m_low = ~b[7-i]; tick(HP);
      scl_m = 1'b1;    tick(HP);
      scl_m = 1'b0;    tick(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    ack = (sda_line == 1'b0);
    tick(HP/2);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    b = '0;
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      scl_m = 1'b1; tick(HP/2);
      b = {b[6:0], sda_line};
      tick(HP/2);
      scl_m = 1'b0; tick(2);
    end
    m_low = ~nack; tick(HP);
    scl_m = 1'b1; tick(HP/2);
    check(sda_oe == 1'b0, "R9 released in master ack slot", sda_oe, 0);
    tick(HP/2);
    scl_m = 1'b0; tick(2);
    m_low = 1'b0;
  endtask

  task automatic addr_phase(input logic [16:0] a, output bit ok);
    bit k0, k1, k2;
    bus_start();
    send_byte(devw(a[16]), k0);
    send_byte(a[15:8], k1);
    send_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  task automatic byte_write(input logic [16:0] a, input logic [7:0] d);
    bit ok, k3;
    addr_phase(a, ok);
    send_byte(d, k3);
    bus_stop();
    check(ok & k3, "R3 all write bytes acked", {ok, k3}, 3);
  endtask

  task automatic rand_read(input logic [16:0] a, output logic [7:0] d);
    bit ok, k;
    addr_phase(a, ok);
    bus_start();
    send_byte(devr(), k);
    recv_byte(1'b1, d);
    bus_stop();
    check(ok & k, "R7 random read acked", {ok, k}, 3);
  endtask

  task automatic cur_read(output logic [7:0] d);
    bit k;
    bus_start();
    send_byte(devr(), k);
    recv_byte(1'b1, d);
    bus_stop();
    check(k, "R6 read device byte acked", k, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, d2;
    bit ok, k;
    tick(5);
    // R11: reset leaves SDA released
    check(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
    rst = 1'b0;
    tick(5);
    check(sda_oe == 1'b0, "R11 sda released after reset", sda_oe, 0);

    // table walk: R3 byte write then R7 random read of each entry (R2 bit 16)
    for (int i = 0; i < 6; i++) begin
      byte_write(VEC[i][24:8], VEC[i][7:0]);
      rand_read(VEC[i][24:8], d);
      check(d == VEC[i][7:0], "R7 R2 readback of table entry", d, VEC[i][7:0]);
    end
    rand_read(17'h00123, d);
    check(d == 8'h3C, "R2 bit16 separates locations", d, 8'h3C);

    // R4: page write from offset 0xFE wraps inside the page
    addr_phase(17'h102FE, ok);
    send_byte(8'h11, k); ok &= k;
    send_byte(8'h22, k); ok &= k;
    send_byte(8'h33, k); ok &= k;
    send_byte(8'h44, k); ok &= k;
    bus_stop();
    check(ok, "R4 page write bytes acked", ok, 1);
    rand_read(17'h10200, d);
    check(d == 8'h33, "R4 third byte wrapped to offset 0", d, 8'h33);
    // R6: counter now at 0x10201
    cur_read(d);
    check(d == 8'h44, "R6 current address read", d, 8'h44);
    rand_read(17'h102FF, d);
    check(d == 8'h22, "R4 second byte at offset FF", d, 8'h22);

    // R8: sequential read wrapping from the top of the array
    byte_write(17'h1FFFF, 8'hE7);
    byte_write(17'h00000, 8'h18);
    byte_write(17'h000FF, 8'h6D);
    byte_write(17'h00100, 8'h9E);
    addr_phase(17'h1FFFF, ok);
    bus_start();
    send_byte(devr(), k);
    recv_byte(1'b0, d);
    recv_byte(1'b1, d2);
    bus_stop();
    check(d == 8'hE7 && d2 == 8'h18, "R8 wrap 1FFFF to 00000",
          {d, d2}, 16'hE718);
    addr_phase(17'h000FF, ok);
    bus_start();
    send_byte(devr(), k);
    recv_byte(1'b0, d);
    recv_byte(1'b1, d2);
    bus_stop();
    check(d == 8'h6D && d2 == 8'h9E, "R8 read crosses page", {d, d2}, 16'h6D9E);

    // R1: strap mismatch and wrong prefix get no ACK
    bus_start();
    send_byte({5'b10100, ~strap, 2'b00}, k);
    check(!k, "R1 strap mismatch not acked", k, 0);
    send_byte(8'h01, k);
    check(!k, "R1 stays released after mismatch", k, 0);
    bus_stop();
    bus_start();
    send_byte(8'h90, k);
    check(!k, "R1 wrong prefix not acked", k, 0);
    bus_stop();
    rand_read(17'h00123, d);
    check(d == 8'h3C, "R1 mismatch wrote nothing", d, 8'h3C);

    // R5: repeated START discards a staged byte
    addr_phase(17'h00055, ok);
    send_byte(8'h77, k);
    rand_read(17'h00055, d);
    check(d == 8'h00, "R5 staged byte discarded on Sr", d, 8'h00);

    // R10: STOP three bits into a data byte stores nothing
    addr_phase(17'h00055, ok);
    send_bits(8'hFF, 3);
    bus_stop();
    rand_read(17'h00055, d);
    check(d == 8'h00, "R10 partial byte not stored", d, 8'h00);

    // R10: START in the middle of a device byte restarts the address search
    bus_start();
    send_bits(devw(1'b1), 4);
    rand_read(17'h1F00F, d);
    check(d == 8'h81, "R10 restart after mid-byte START", d, 8'h81);

    // R11: reset clears the counter and keeps the array
    rand_read(17'h10123, d);
    rst = 1'b1; tick(5);
    rst = 1'b0; tick(5);
    cur_read(d);
    check(d == 8'h18, "R11 counter zero after reset", d, 8'h18);

    summary();
  end
endmodule